// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer Bank

The block holds six identical 16-bit up-counting timers behind one 16-bit register port. Every timer has a setup word, a count word and a match word. A slow tick input, nominally 32 kHz, passes through a shared power-of-two divider. Each timer picks its own divide ratio through a select field in its setup word. When an enabled timer counts up to its match value, it raises a sticky match flag. It can also pulse a system reset request, a non-maskable interrupt request, or both. A shared 32-bit action-enable word decides which of these pulses a given timer may cause.

The configuration part of a setup word is fixed by its first write and stays fixed until reset. After that first write, only the run bit and the match flag respond to further writes. The run bit starts and stops counting. A 1 written to the flag position clears the flag. Software can treat a setup word that reads zero as a free timer. A typical use is a watchdog. Software stops the timer, loads the count, starts it again, and arms the reset action. If the count reaches the match value before the next reload, the reset request fires.

Top module: `mtimer_bank`

## Requirements
- R1: After reset every register reads 0, and `rst_req` and `nmi_req` are low.
- R2: The first write to a timer's setup word stores bits [6:0] as its configuration (bits [3:0] select the divide ratio). Later writes leave bits [6:0] unchanged until reset.
- R3: Every write to a setup word, the first one included, stores bit 15 as the run bit. The setup word reads back as {run, flag, 0, 6'b0, config[6:0]}.
- R4: A setup write with bit 14 at 1 clears that timer's match flag. A write with bit 14 at 0 leaves the flag as it is.
- R5: A setup word that has never been written reads 0.
- R6: A running timer whose select is s advances by one on each tick_in pulse that arrives while the low s bits of the shared tick count (tick_in pulses since reset) are all 1. A stopped timer holds its count.
- R7: A write to the count word takes effect only while the run bit is 0. While the timer runs, the write is ignored.
- R8: The count wraps from 0xFFFF to 0x0000.
- R9: When a timer advances to a value equal to its match word, its match flag (setup bit 14) sets in the same edge.
- R10: On that match, `rst_req` is high for exactly the one cycle after the edge, but only if the timer's reset-enable bit (action word bit 16+i) is 1.
- R11: On that match, `nmi_req` pulses in the same cycle, but only if the timer's NMI-enable bit (action word bit i) is 1.
- R12: The action word reads and writes in two halves: bits [15:0] at address 28 and bits [31:16] at address 29. Timer i uses addresses 4i (setup), 4i+1 (count) and 4i+2 (match).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle pulse per slow-clock period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {index[2:0], field[1:0]} |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| nmi_req | output | 1 | One-cycle NMI request |

## Verification
A table-driven pass sends setup, count and match writes to the bank: first writes, repeated writes with different configuration bits, count loads while running and while stopped, and action-word halves. The readback separates the field that locks from the run bit, which stays writable. A timer loaded three below the wrap point with a match value of 1 shows the wrap, the flag and the reset pulse together, and the flag's write-1-clear is checked against a write of 0. A timer with a divide of four, run across eight ticks and then stopped, separates correct divider phasing from counting on every tick and from counting while stopped. A last timer, with only its NMI action armed, shows that the two actions are gated independently.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int TMR_W     = 16;
  localparam int SEL_W     = 4;
  localparam int PRE_W     = (1 << SEL_W) - 1;
  localparam int CFG_W     = 7;
  localparam int SU_RUN    = 15;
  localparam int SU_FLAG   = 14;

  // Divider fires when the low 'sel' bits of the shared tick count are all ones.
  function automatic logic div_fire(logic [PRE_W-1:0] pc, logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] mask;
    mask = (PRE_W'(1) << sel) - PRE_W'(1);
    return (pc & mask) == mask;
  endfunction

  function automatic logic [TMR_W-1:0] next_count(logic [TMR_W-1:0] c);
    return c + TMR_W'(1);
  endfunction
endpackage

// File: rtl/mtb_prescale.sv
module mtb_prescale #(
  parameter int W = mtb_pkg::PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  output logic [W-1:0] pre_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (tick_in) pre_cnt <= pre_cnt + W'(1);
  end
endmodule

// File: rtl/mtb_action_reg.sv
module mtb_action_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [15:0]  wdata,
  output logic [31:0]  q,
  output logic [N-1:0] nmi_en,
  output logic [N-1:0] rst_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else begin
      if (we_lo) q[15:0]  <= wdata;
      if (we_hi) q[31:16] <= wdata;
    end
  end
  assign nmi_en = q[N-1:0];
  assign rst_en = q[16+N-1:16];
endmodule

// File: rtl/mtb_timer.sv
module mtb_timer
  import mtb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PRE_W-1:0]    pre_cnt,
  input  logic                tick_in,
  input  logic                setup_we,
  input  logic                count_we,
  input  logic                match_we,
  input  logic [TMR_W-1:0]    wdata,
  output logic [TMR_W-1:0]    setup_rd,
  output logic [TMR_W-1:0]    count,
  output logic [TMR_W-1:0]    match,
  output logic [CFG_W-1:0]    cfg,
  output logic                run,
  output logic                flag,
  output logic                locked,
  output logic                tick,
  output logic                hit
);
  assign tick = tick_in & div_fire(pre_cnt, cfg[SEL_W-1:0]);
  assign hit  = run & tick & (next_count(count) == match);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      locked <= 1'b0;
      run    <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (setup_we) begin
        run <= wdata[SU_RUN];
        if (!locked) begin
          cfg    <= wdata[CFG_W-1:0];
          locked <= 1'b1;
        end
      end
      if (hit)                             flag <= 1'b1;
      else if (setup_we && wdata[SU_FLAG]) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      match <= '0;
    end else begin
      if (count_we && !run)  count <= wdata;
      else if (run && tick)  count <= next_count(count);
      if (match_we)          match <= wdata;
    end
  end

  assign setup_rd = locked ? {run, flag, 1'b0, 6'b0, cfg} : '0;
endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
  import mtb_pkg::*;
#(
  parameter int N  = 6,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          rst_req,
  output logic          nmi_req
);
  localparam int IDX_W   = AW - 2;
  localparam int ACT_IDX = (1 << IDX_W) - 1;

  logic [IDX_W-1:0] idx;
  logic [1:0]       fld;
  assign idx = reg_addr[AW-1:2];
  assign fld = reg_addr[1:0];

  logic [PRE_W-1:0] pre_cnt;
  logic [31:0]      act_q;
  logic [N-1:0]     nmi_en, rst_en;

  logic [N-1:0][TMR_W-1:0] tmr_setup, tmr_count, tmr_match;
  logic [N-1:0][CFG_W-1:0] tmr_cfg;
  logic [N-1:0] tmr_run, tmr_flag, tmr_locked, tmr_tick, tmr_hit;

  mtb_prescale #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .pre_cnt(pre_cnt)
  );

  mtb_action_reg #(.N(N)) u_act (
    .clk(clk), .rst_n(rst_n),
    .we_lo(reg_we && idx == IDX_W'(ACT_IDX) && fld == 2'd0),
    .we_hi(reg_we && idx == IDX_W'(ACT_IDX) && fld == 2'd1),
    .wdata(reg_wdata), .q(act_q), .nmi_en(nmi_en), .rst_en(rst_en)
  );

  for (genvar g = 0; g < N; g++) begin : g_tmr
    logic sel;
    assign sel = reg_we && idx == IDX_W'(g);
    mtb_timer u_tmr (
      .clk(clk), .rst_n(rst_n), .pre_cnt(pre_cnt), .tick_in(tick_in),
      .setup_we(sel && fld == 2'd0),
      .count_we(sel && fld == 2'd1),
      .match_we(sel && fld == 2'd2),
      .wdata(reg_wdata),
      .setup_rd(tmr_setup[g]), .count(tmr_count[g]), .match(tmr_match[g]),
      .cfg(tmr_cfg[g]), .run(tmr_run[g]), .flag(tmr_flag[g]),
      .locked(tmr_locked[g]), .tick(tmr_tick[g]), .hit(tmr_hit[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (idx == IDX_W'(ACT_IDX)) begin
      if (fld == 2'd0)      reg_rdata = act_q[15:0];
      else if (fld == 2'd1) reg_rdata = act_q[31:16];
    end else begin
      for (int i = 0; i < N; i++) begin
        if (idx == IDX_W'(i)) begin
          case (fld)
            2'd0:    reg_rdata = tmr_setup[i];
            2'd1:    reg_rdata = tmr_count[i];
            2'd2:    reg_rdata = tmr_match[i];
            default: reg_rdata = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      rst_req <= |(tmr_hit & rst_en);
      nmi_req <= |(tmr_hit & nmi_en);
    end
  end
endmodule

// File: rtl/mtb_checker.sv
module mtb_checker
  import mtb_pkg::*;
#(
  parameter int N = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N-1:0]            hit,
  input logic [N-1:0]            flag,
  input logic [N-1:0]            run,
  input logic [N-1:0]            locked,
  input logic [N-1:0]            tick,
  input logic [N-1:0][TMR_W-1:0] count,
  input logic [N-1:0][CFG_W-1:0] cfg,
  input logic [N-1:0]            rst_en,
  input logic [N-1:0]            nmi_en,
  input logic                    rst_req,
  input logic                    nmi_req
);
  for (genvar g = 0; g < N; g++) begin : g_chk
    // R9
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag[g]);
    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked[g] |=> $stable(cfg[g]));
    // R6
    run_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && tick[g]) |=> count[g] == TMR_W'($past(count[g]) + 1));
    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && !tick[g]) |=> $stable(count[g]));
  end
  // R10
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req == $past(|(hit & rst_en)));
  // R11
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == $past(|(hit & nmi_en)));
endmodule

bind mtimer_bank mtb_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(tmr_hit), .flag(tmr_flag), .run(tmr_run),
  .locked(tmr_locked), .tick(tmr_tick), .count(tmr_count), .cfg(tmr_cfg),
  .rst_en(rst_en), .nmi_en(nmi_en), .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/mtimer_bank_tb.sv
module mtimer_bank_tb;
  localparam int CLK_PER = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rst_req, nmi_req;

  int n_chk = 0, n_bad = 0, n_tick = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  mtimer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  // {op(0 write,1 read-check), addr, data, expected}
  localparam logic [38:0] VEC [NV] = '{
    {2'd1, 5'd8,  16'h0000, 16'h0000}, // R5 unused timer 2
    {2'd0, 5'd8,  16'h0023, 16'h0000}, // R2 first write locks cfg
    {2'd1, 5'd8,  16'h0000, 16'h0023},
    {2'd0, 5'd8,  16'h8041, 16'h0000}, // R3 run set, cfg kept
    {2'd1, 5'd8,  16'h0000, 16'h8023},
    {2'd0, 5'd9,  16'h1234, 16'h0000}, // R7 ignored while running
    {2'd1, 5'd9,  16'h0000, 16'h0000},
    {2'd0, 5'd8,  16'h007F, 16'h0000}, // R3 stop, R2 cfg kept
    {2'd1, 5'd8,  16'h0000, 16'h0023},
    {2'd0, 5'd9,  16'h1234, 16'h0000}, // R7 accepted while stopped
    {2'd1, 5'd9,  16'h0000, 16'h1234},
    {2'd0, 5'd10, 16'hBEEF, 16'h0000},
    {2'd1, 5'd10, 16'h0000, 16'hBEEF},
    {2'd0, 5'd29, 16'h0004, 16'h0000}, // R12 upper half
    {2'd1, 5'd29, 16'h0000, 16'h0004},
    {2'd1, 5'd28, 16'h0000, 16'h0000}, // R12 lower half untouched
    {2'd1, 5'd0,  16'h0000, 16'h0000}, // R5 timer 0
    {2'd1, 5'd4,  16'h0000, 16'h0000}  // R5 timer 1
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_in = 1'b1;
    @(negedge clk);
    tick_in = 1'b0;
    n_tick++;
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [15:0] d;
    int exp1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d);
      chk("R1 reset readback", d, 16'h0000);
    end
    chk("R1 rst_req idle", {15'b0, rst_req}, 16'h0000);
    chk("R1 nmi_req idle", {15'b0, nmi_req}, 16'h0000);

    // table pass
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38:37] == 2'd0) wr(VEC[i][36:32], VEC[i][31:16]);
      else begin
        @(negedge clk);
        rd(VEC[i][36:32], d);
        chk($sformatf("table %0d (R2 R3 R5 R7 R12)", i), d, VEC[i][15:0]);
      end
    end

    // Timer 0: wrap and reset action
    wr(5'd1, 16'hFFFD);
    wr(5'd2, 16'h0001);
    wr(5'd29, 16'h0001);
    wr(5'd28, 16'h0000);
    wr(5'd0, 16'h8000);
    tick(); tick();
    rd(5'd1, d); chk("R6 count after two ticks", d, 16'hFFFF);
    tick();
    rd(5'd1, d); chk("R8 wrap to zero", d, 16'h0000);
    chk("R10 no early reset", {15'b0, rst_req}, 16'h0000);
    tick();
    chk("R10 reset pulse on match", {15'b0, rst_req}, 16'h0001);
    chk("R11 no nmi without enable", {15'b0, nmi_req}, 16'h0000);
    rd(5'd0, d); chk("R9 flag set on match", d, 16'hC000);
    @(negedge clk);
    chk("R10 pulse lasts one cycle", {15'b0, rst_req}, 16'h0000);
    wr(5'd0, 16'h8000);
    rd(5'd0, d); chk("R4 zero write keeps flag", d, 16'hC000);
    wr(5'd0, 16'hC000);
    rd(5'd0, d); chk("R4 one write clears flag", d, 16'h8000);

    // Timer 1: divide by four
    wr(5'd4, 16'h8002);
    exp1 = 0;
    for (int k = 0; k < 8; k++) begin
      if ((n_tick % 4) == 3) exp1++;
      tick();
    end
    rd(5'd5, d); chk("R6 divide-by-four count", d, 16'(exp1));
    wr(5'd4, 16'h0002);
    tick(); tick(); tick();
    rd(5'd5, d); chk("R6 stopped timer holds", d, 16'(exp1));

    // Timer 3: NMI action only
    wr(5'd14, 16'h0002);
    wr(5'd28, 16'h0008);
    wr(5'd29, 16'h0001);
    wr(5'd12, 16'h8000);
    tick();
    chk("R11 no nmi before match", {15'b0, nmi_req}, 16'h0000);
    tick();
    chk("R11 nmi pulse on match", {15'b0, nmi_req}, 16'h0001);
    chk("R10 no reset when disabled", {15'b0, rst_req}, 16'h0000);
    rd(5'd12, d); chk("R9 timer 3 flag", d, 16'hC000);
    @(negedge clk);
    chk("R11 nmi pulse ends", {15'b0, nmi_req}, 16'h0000);

    done = 1;
    finish_up();
  end
endmodule